// File: doc/BRIEF.md
# APB Write Transfer Protocol Monitor

A passive observer placed on an APB bus segment. It never drives the bus. Each cycle it works out which phase the bus is in: idle, the setup cycle, an access cycle that is still waiting, or the completing access cycle. From that it raises a per-cycle error pulse for each protocol rule the bus breaks in that cycle. Each pulse also sets a matching sticky bit, and only reset clears the sticky bits.

The monitor also raises a commit strobe on every cycle in which a write lands. It counts those cycles in a wrapping counter, so software-free test setups can tally writes on a bus that runs transfers back to back.

While a transfer is stretched by wait states, the monitor checks the address, direction and write data. It compares them against copies it captured during the setup cycle. It also checks that each transfer lands at most once before the next setup or idle cycle.

Top module: `apb_wr_monitor`

## Requirements
- R1: `commit` is high in exactly the cycles where `bus_sel`, `bus_enable`, `bus_write` and `bus_ready` are all high. It is combinational, so it is seen in the same cycle. A setup cycle or a waiting access cycle never raises it.
- R2: A cycle with `bus_write` low never raises `commit`, and it leaves `wr_count` unchanged.
- R3: `err_pulse[0]` (missing setup) is high in an access cycle (`bus_sel` and `bus_enable` high) whose previous cycle was neither a setup cycle (`bus_sel` high, `bus_enable` low) nor a waiting access cycle of a pending transfer.
- R4: `err_pulse[1]` (instability) is high in any cycle of a pending transfer in which one of these holds:
  - `bus_sel` is low;
  - it is an access cycle and `bus_addr`, `bus_write` or `bus_wdata` differs from the value captured in the setup cycle.
- R5: `err_pulse[2]` (enable held) is high in the cycle after a completing access cycle if `bus_enable` is still high.
- R6: `err_pulse[3]` (double commit) is high on a commit cycle when an earlier commit has occurred with no setup cycle and no cycle of `bus_sel` low in between.
- R7: Each `err_sticky` bit becomes 1 on the clock edge after its pulse. It then stays 1 until reset.
- R8: `wr_count` (16 bits) increases by one on the edge after each commit cycle. It wraps from 65535 to 0.
- R9: During and directly after reset, `err_sticky` and `wr_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Observed select |
| bus_enable | input | 1 | Observed enable |
| bus_write | input | 1 | Observed direction, 1 = write |
| bus_ready | input | 1 | Observed subordinate ready |
| bus_addr | input | ADDR_W | Observed address |
| bus_wdata | input | DATA_W | Observed write data |
| commit | output | 1 | Write lands in this cycle |
| err_pulse | output | 4 | Rules broken this cycle: [0] missing setup, [1] instability, [2] enable held, [3] double commit |
| err_sticky | output | 4 | Accumulated error bits, same order |
| wr_count | output | CNT_W | Wrapping count of commit cycles |

## Verification
How each internal fault shows at the ports:
- A wrong pending flag shows in the same cycle, as a false or missing `err_pulse[0]` or `err_pulse[1]` on the first access cycle.
- A stale setup copy makes a legal waited transfer report instability on its first wait cycle.
- A wrong completion or commit-history flag shows one cycle after the completion, in `err_pulse[2]` or `err_pulse[3]`.
- A counter fault shows in `wr_count` on the edge after a commit. A wrap fault shows only after 65536 commits, so the bench runs that many.

// File: rtl/apb_wr_mon_pkg.sv
package apb_wr_mon_pkg;
  localparam int ERR_W        = 4;
  localparam int ERR_NOSETUP  = 0;
  localparam int ERR_UNSTABLE = 1;
  localparam int ERR_ENHELD   = 2;
  localparam int ERR_DOUBLE   = 3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_WAIT   = 2'd2,
    PH_FINISH = 2'd3
  } phase_e;

  function automatic phase_e classify(input logic sel, input logic en, input logic rdy);
    if (!sel)     return PH_IDLE;
    else if (!en) return PH_SETUP;
    else if (!rdy) return PH_WAIT;
    else          return PH_FINISH;
  endfunction
endpackage

// File: rtl/apb_wr_mon_phase.sv
module apb_wr_mon_phase
  import apb_wr_mon_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   commit_now,
  output logic   pending,
  output logic   prev_finish,
  output logic   committed
);
  logic pending_next, committed_next;

  always_comb begin
    pending_next = (phase == PH_SETUP) || ((phase == PH_WAIT) && pending);
    if (phase == PH_SETUP || phase == PH_IDLE) committed_next = 1'b0;
    else if (commit_now)                       committed_next = 1'b1;
    else                                       committed_next = committed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      prev_finish <= 1'b0;
      committed   <= 1'b0;
    end else begin
      pending     <= pending_next;
      prev_finish <= (phase == PH_FINISH);
      committed   <= committed_next;
    end
  end

  AST_SETUP_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SETUP) |=> pending); // R3
endmodule

// File: rtl/apb_wr_mon_ref.sv
module apb_wr_mon_ref #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [DATA_W-1:0] wdata,
  output logic              mismatch
);
  localparam int REF_W = ADDR_W + DATA_W + 1;

  logic [REF_W-1:0] ref_q;
  logic [REF_W-1:0] live;

  function automatic logic differs(input logic [REF_W-1:0] a, input logic [REF_W-1:0] b);
    return |(a ^ b);
  endfunction

  assign live     = {addr, write, wdata};
  assign mismatch = differs(live, ref_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ref_q <= '0;
    else if (capture) ref_q <= live;
  end

  AST_REF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(ref_q)); // R4
endmodule

// File: rtl/apb_wr_mon_count.sv
module apb_wr_mon_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= step(count);
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> count == $past(count) + 1'b1); // R8
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(count)); // R2
endmodule

// File: rtl/apb_wr_monitor.sv
module apb_wr_monitor
  import apb_wr_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_enable,
  input  logic              bus_write,
  input  logic              bus_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              commit,
  output logic [ERR_W-1:0]  err_pulse,
  output logic [ERR_W-1:0]  err_sticky,
  output logic [CNT_W-1:0]  wr_count
);
  phase_e phase;
  logic   pending, prev_finish, committed, mismatch;
  logic   in_access;

  assign phase     = classify(bus_sel, bus_enable, bus_ready);
  assign in_access = (phase == PH_WAIT) || (phase == PH_FINISH);
  assign commit    = (phase == PH_FINISH) && bus_write;

  apb_wr_mon_phase u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .commit_now(commit),
    .pending(pending), .prev_finish(prev_finish), .committed(committed)
  );

  apb_wr_mon_ref #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ref (
    .clk(clk), .rst_n(rst_n), .capture(phase == PH_SETUP),
    .addr(bus_addr), .write(bus_write), .wdata(bus_wdata), .mismatch(mismatch)
  );

  apb_wr_mon_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .inc(commit), .count(wr_count)
  );

  always_comb begin
    err_pulse               = '0;
    err_pulse[ERR_NOSETUP]  = in_access && !pending;
    err_pulse[ERR_UNSTABLE] = pending && ((phase == PH_IDLE) || (in_access && mismatch));
    err_pulse[ERR_ENHELD]   = prev_finish && bus_enable;
    err_pulse[ERR_DOUBLE]   = commit && committed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_sticky <= '0;
    else        err_sticky <= err_sticky | err_pulse;
  end

  AST_READ_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_write |-> !commit); // R2
  AST_SETUP_BEFORE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_enable && !err_pulse[ERR_NOSETUP]) |-> $past(bus_sel)); // R3
  AST_DOUBLE_IMPLIES_NOSETUP: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse[ERR_DOUBLE] |-> err_pulse[ERR_NOSETUP]); // R6
  AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_sticky & ($past(err_sticky) | $past(err_pulse))) ==
              ($past(err_sticky) | $past(err_pulse)))); // R7
  AST_FINISH_THEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !bus_write) |-> 1'b0); // R1
endmodule

// File: tb/apb_wr_monitor_tb_top.sv
module apb_wr_monitor_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 0, en = 0, wr = 0, rdy = 0;
  logic [31:0] addr = '0, wdata = '0;
  logic        commit;
  logic [3:0]  err_pulse, err_sticky;
  logic [15:0] wr_count;

  int          n_checks = 0, n_errors = 0;
  logic [15:0] exp_cnt = '0;
  logic [3:0]  exp_sticky = '0;
  bit          fast = 0;

  always #(CLK_P/2) clk = ~clk;

  apb_wr_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_enable(en), .bus_write(wr),
    .bus_ready(rdy), .bus_addr(addr), .bus_wdata(wdata), .commit(commit),
    .err_pulse(err_pulse), .err_sticky(err_sticky), .wr_count(wr_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic e, input logic w, input logic r,
                     input logic [31:0] a, input logic [31:0] d,
                     input logic [3:0] xp, input logic xc, input string req);
    @(negedge clk);
    if (!fast) begin
      check({"R8 count ", req}, {16'h0, wr_count}, {16'h0, exp_cnt});
      check({"R7 sticky ", req}, {28'h0, err_sticky}, {28'h0, exp_sticky});
    end
    sel = s; en = e; wr = w; rdy = r; addr = a; wdata = d;
    #1;
    if (!fast) begin
      check({"pulse ", req}, {28'h0, err_pulse}, {28'h0, xp});
      check({"R1 commit ", req}, {31'h0, commit}, {31'h0, xc});
    end
    exp_cnt    = exp_cnt + {15'h0, xc};
    exp_sticky = exp_sticky | xp;
  endtask

  task automatic xfer(input logic w, input int waits, input logic [31:0] a, input logic [31:0] d);
    cyc(1, 0, w, waits[0], a, d, 4'h0, 1'b0, "R1 setup");
    for (int k = 0; k < waits; k++) cyc(1, 1, w, 0, a, d, 4'h0, 1'b0, "R1 wait");
    cyc(1, 1, w, 1, a, d, 4'h0, w, w ? "R1 finish" : "R2 read finish");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sel = 0; en = 0; wr = 0; rdy = 0;
    #1;
    check("R9 reset count", {16'h0, wr_count}, 32'h0);
    check("R9 reset sticky", {28'h0, err_sticky}, 32'h0);
    @(negedge clk);
    rst_n = 1;
    exp_cnt = '0; exp_sticky = '0;
  endtask

  initial begin
    do_reset();
    for (int w = 0; w < 2; w++)
      for (int wt = 0; wt < 4; wt++)
        for (int gap = 0; gap < 2; gap++) begin
          xfer(w[0], wt, 32'h100 + w*16 + wt*2 + gap, 32'hA000 + wt*3 + w);
          if (gap == 1) cyc(0, 0, 0, 0, '0, '0, 4'h0, 1'b0, "R1 idle");
        end
    cyc(0, 0, 0, 0, '0, '0, 4'h0, 1'b0, "idle");
    cyc(1, 1, 1, 1, 32'h10, 32'h1, 4'b0001, 1'b1, "R3 no setup");
    cyc(0, 0, 0, 0, '0, '0, 4'h0, 1'b0, "idle");
    cyc(1, 0, 1, 0, 32'h20, 32'h5, 4'h0, 1'b0, "R4 setup");
    cyc(1, 1, 1, 0, 32'h21, 32'h5, 4'b0010, 1'b0, "R4 addr change");
    cyc(1, 1, 1, 1, 32'h20, 32'h5, 4'h0, 1'b1, "R4 restored");
    cyc(1, 0, 1, 0, 32'h30, 32'h6, 4'h0, 1'b0, "R4 setup");
    cyc(1, 1, 1, 0, 32'h30, 32'h7, 4'b0010, 1'b0, "R4 data change");
    cyc(1, 1, 0, 0, 32'h30, 32'h6, 4'b0010, 1'b0, "R4 dir change");
    cyc(1, 1, 1, 1, 32'h30, 32'h6, 4'h0, 1'b1, "R4 finish");
    cyc(1, 0, 1, 0, 32'h40, 32'h8, 4'h0, 1'b0, "R4 setup");
    cyc(0, 0, 1, 0, 32'h40, 32'h8, 4'b0010, 1'b0, "R4 sel dropped");
    xfer(1, 0, 32'h50, 32'h9);
    cyc(0, 1, 1, 1, 32'h50, 32'h9, 4'b0100, 1'b0, "R5 enable held idle");
    xfer(1, 1, 32'h60, 32'hA);
    cyc(1, 1, 1, 1, 32'h60, 32'hA, 4'b1101, 1'b1, "R6 double commit");
    cyc(0, 0, 0, 0, '0, '0, 4'h0, 1'b0, "R7 idle");
    cyc(0, 0, 0, 0, '0, '0, 4'h0, 1'b0, "R7 hold");
    do_reset();
    cyc(0, 0, 0, 0, '0, '0, 4'h0, 1'b0, "R9 after reset");
    fast = 1;
    for (int i = 0; i < 65535; i++) xfer(1, 0, 32'h4, i);
    fast = 0;
    cyc(0, 0, 0, 0, '0, '0, 4'h0, 1'b0, "R8 before wrap");
    xfer(1, 0, 32'h8, 32'hFF);
    cyc(0, 0, 0, 0, '0, '0, 4'h0, 1'b0, "R8 wrapped");
    @(negedge clk);
    check("R8 wrap to zero", {16'h0, wr_count}, 32'h0);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule